// File: doc/BRIEF.md
# Asynchronous Strobe-Driven Register Bus Slave

This block lets an external host processor read and write a bank of 8-bit registers through a multiplexed-style asynchronous bus. The host presents a 7-bit address and pulses an active-high address strobe. The address is taken when that strobe falls, and the falling edge opens a new access. The host then pulls either the active-low read strobe or the active-low write strobe. The block answers on an active-low ready line. The host must keep its strobe asserted, stretching the access, until ready goes low.

All host signals are asynchronous to the system clock. The block passes them through a chain of flip-flops before any decision is made. The bidirectional data bus is split at the block boundary into an input, an output and an output enable, and the pad cell is left to the chip top. Read data is driven only while the raw read strobe is low. A write is committed when the synchronised write strobe returns high. An access in which both strobes are low together is discarded.

Top module: `async_regbus_slave`

## Requirements
- R1: The target address is the value on `bus_addr` while `bus_ale` was last high. Changes on `bus_addr` after `bus_ale` falls do not alter the register read or written.
- R2: While `bus_rd_n` is low and `bus_wr_n` is high, `bus_doe` is 1 and `bus_dout` carries the contents of the latched register.
- R3: When `bus_rd_n` is high, `bus_doe` is 0 and `bus_dout` is 0.
- R4: When `bus_wr_n` rises, the register at the latched address takes the value that `bus_din` held while `bus_wr_n` was low. Every other register is left unchanged.
- R5: After a single strobe goes low, `bus_rdy_n` stays high for exactly SYNC_STAGES+RDY_DLY clock edges and then goes low. With the defaults of 2 and 2, it goes low after the 4th rising edge.
- R6: After the strobe returns high, `bus_rdy_n` returns high after SYNC_STAGES rising edges, which is 2 with the defaults.
- R7: If `bus_rd_n` and `bus_wr_n` are low together, `bus_doe` stays 0, `bus_rdy_n` stays high and no register is written, until the next falling edge of `bus_ale`.
- R8: While `rst_n` is low at a rising edge, every register is cleared to 0. During reset `bus_doe` is 0 and `bus_rdy_n` is 1.
- R9: A write access does not drive the bus: `bus_doe` is 0 while `bus_wr_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 7 | Host address |
| bus_ale | input | 1 | Address strobe, active high; address taken on its fall |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_din | input | 8 | Data from host (pad input side) |
| bus_dout | output | 8 | Read data toward the pad |
| bus_doe | output | 1 | Pad output enable; 0 means tri-stated |
| bus_rdy_n | output | 1 | Ready, active low; host stretches access while high |

## Verification
A wrong latched address shows at the ports on the next read. That read returns the pattern that belongs to a neighbouring location, and every location is swept, so the error is seen within one pass. A miscounted handshake shows as a ready edge one clock early or late. This is visible on the same access, because the bench measures every ready assertion and release to the clock. A lost or misdirected write stays hidden until the location is read back. For that reason each full write sweep is followed by a full read sweep, and conflicting accesses are followed by read-back of the touched register.

// File: rtl/async_regbus_pkg.sv
package async_regbus_pkg;
  localparam int ADDR_W      = 7;
  localparam int DATA_W      = 8;
  localparam int SYNC_STAGES = 2;
  localparam int RDY_DLY     = 2;

  // width of a counter that must reach value n
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // rising clock edges from a strobe falling to ready being seen low
  function automatic int ready_latency(input int stages, input int dly);
    return stages + dly;
  endfunction
endpackage

// File: rtl/rb_sync.sv
module rb_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) stg <= RST_VAL;
        else        stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rb_addr_latch.sv
module rb_addr_latch #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_s,
  input  logic [ADDR_W-1:0] addr_s,
  output logic              ale_fall,
  output logic [ADDR_W-1:0] addr_q
);
  logic ale_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_d  <= 1'b0;
      addr_q <= '0;
    end else begin
      ale_d <= ale_s;
      if (ale_s) addr_q <= addr_s;
    end
  end

  assign ale_fall = ale_d & ~ale_s;

  // R1: once the strobe is low the target address is frozen
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_s |=> $stable(addr_q));
endmodule

// File: rtl/rb_regfile.sv
module rb_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem;

  always_ff @(posedge clk) begin
    if (!rst_n)  mem        <= '0;
    else if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R4: storage changes only on a commit
  a_r4_store_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));
endmodule

// File: rtl/rb_handshake.sv
module rb_handshake #(
  parameter int DATA_W = 8,
  parameter int DLY    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_seen,
  input  logic              wr_seen,
  input  logic              ale_fall,
  input  logic [DATA_W-1:0] din_s,
  output logic              rdy_n,
  output logic              conflict,
  output logic              wr_commit,
  output logic [DATA_W-1:0] wdata
);
  import async_regbus_pkg::*;
  localparam int CNT_W = cnt_width(DLY);

  logic wr_d;
  logic conflict_q;
  logic active;
  logic wr_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_d       <= 1'b0;
      conflict_q <= 1'b0;
      wdata      <= '0;
    end else begin
      wr_d <= wr_seen;
      if (rd_seen && wr_seen) conflict_q <= 1'b1;
      else if (ale_fall)      conflict_q <= 1'b0;
      if (wr_seen && !rd_seen) wdata <= din_s;
    end
  end

  assign conflict  = conflict_q;
  assign active    = (rd_seen ^ wr_seen) & ~conflict_q;
  assign wr_rise   = wr_d & ~wr_seen;
  assign wr_commit = wr_rise & ~conflict_q & ~rd_seen;

  generate
    if (DLY == 0) begin : g_nodly
      assign rdy_n = ~active;
    end else begin : g_cnt
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || !active)           cnt <= '0;
        else if (cnt != CNT_W'(DLY))     cnt <= cnt + 1'b1;
      end
      assign rdy_n = ~(active && (cnt == CNT_W'(DLY)));
    end
  endgenerate

  // R7: a conflicting access neither commits nor completes
  a_r7_conflict_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_q |-> (!wr_commit && rdy_n));
  // R6: with no strobe seen, ready is released
  a_r6_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_seen && !wr_seen) |-> rdy_n);
endmodule

// File: rtl/async_regbus_slave.sv
module async_regbus_slave #(
  parameter int ADDR_W      = async_regbus_pkg::ADDR_W,
  parameter int DATA_W      = async_regbus_pkg::DATA_W,
  parameter int SYNC_STAGES = async_regbus_pkg::SYNC_STAGES,
  parameter int RDY_DLY     = async_regbus_pkg::RDY_DLY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ale,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              bus_rdy_n
);
  localparam int BUS_W = ADDR_W + DATA_W;

  // synchronised host signals, strobes turned active high
  logic [2:0]        ctl_s;
  logic              ale_s, rd_seen, wr_seen;
  logic [BUS_W-1:0]  bus_s;
  logic [ADDR_W-1:0] addr_s, addr_q;
  logic [DATA_W-1:0] din_s, wdata, rdata;
  logic              ale_fall, conflict, wr_commit;

  rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bus_ale, ~bus_rd_n, ~bus_wr_n}), .q(ctl_s));

  rb_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({bus_addr, bus_din}), .q(bus_s));

  assign {ale_s, rd_seen, wr_seen} = ctl_s;
  assign {addr_s, din_s}           = bus_s;

  rb_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .ale_s(ale_s), .addr_s(addr_s),
    .ale_fall(ale_fall), .addr_q(addr_q));

  rb_handshake #(.DATA_W(DATA_W), .DLY(RDY_DLY)) u_hs (
    .clk(clk), .rst_n(rst_n), .rd_seen(rd_seen), .wr_seen(wr_seen),
    .ale_fall(ale_fall), .din_s(din_s), .rdy_n(bus_rdy_n),
    .conflict(conflict), .wr_commit(wr_commit), .wdata(wdata));

  rb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_commit), .waddr(addr_q),
    .wdata(wdata), .raddr(addr_q), .rdata(rdata));

  // output enable follows the raw read strobe so release is immediate
  assign bus_doe  = rst_n & ~bus_rd_n & bus_wr_n & ~conflict;
  assign bus_dout = bus_doe ? rdata : '0;

  // R7: never drive while a conflict is pending
  a_r7_no_drive_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> !bus_doe);
  // R5: ready only completes an access with exactly one strobe seen
  a_r5_ready_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdy_n |-> (rd_seen != wr_seen));
  // R8: reset leaves ready released and no commit
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (bus_rdy_n && !wr_commit));
  // R9: a seen write strobe never enables the output
  a_r9_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_seen && !bus_wr_n) |-> !bus_doe);
endmodule

// File: tb/async_regbus_slave_test.sv
`timescale 1ns/1ps
module async_regbus_slave_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] bus_addr = '0;
  logic       bus_ale = 1'b0;
  logic       bus_rd_n = 1'b1;
  logic       bus_wr_n = 1'b1;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_doe;
  logic       bus_rdy_n;

  int total = 0;
  int bad = 0;
  localparam int LAT = 2 + 2;   // sync stages + ready delay
  localparam int REL = 2;

  always #10 clk = ~clk;        // 50 MHz

  async_regbus_slave uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_ale(bus_ale),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_rdy_n(bus_rdy_n));

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'(((a * 29) + salt) ^ (a >> 2));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic latch_addr(input logic [6:0] a);
    @(negedge clk); bus_addr = a; bus_ale = 1'b1;
    repeat (3) @(negedge clk);
    bus_ale = 1'b0;
    repeat (3) @(negedge clk);
    bus_addr = ~a;              // R1: later address changes must not matter
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] exp, input bit timing);
    int n;
    latch_addr(a);
    bus_rd_n = 1'b0;
    #1;
    if (timing) check("R2 doe", bus_doe, 1);
    n = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (!bus_rdy_n) begin n = i; break; end
    end
    if (timing) check("R5 ready latency", n, LAT);
    check("R1/R2 read data", bus_dout, exp);
    bus_rd_n = 1'b1;
    #1;
    if (timing) begin
      check("R3 doe released", bus_doe, 0);
      check("R3 dout zero", bus_dout, 0);
    end
    n = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (bus_rdy_n) begin n = i; break; end
    end
    if (timing) check("R6 ready release", n, REL);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input bit timing);
    int n;
    latch_addr(a);
    bus_din = d; bus_wr_n = 1'b0;
    n = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (timing && i == 2) check("R9 no drive on write", bus_doe, 0);
      if (!bus_rdy_n) begin n = i; break; end
    end
    if (timing) check("R5 write ready latency", n, LAT);
    bus_wr_n = 1'b1;
    repeat (REL + 1) @(negedge clk);
    bus_din = ~d;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20ns * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rdy_seen, doe_seen;
    // R8: outputs quiet in reset even with the read strobe low
    bus_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 reset ready", bus_rdy_n, 1);
    check("R8 reset doe", bus_doe, 0);
    bus_rd_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: every register reads zero after reset
    for (int a = 0; a < 128; a++) do_read(7'(a), 8'h00, a < 4);

    // R4: fill every location, then read back all
    for (int a = 0; a < 128; a++) do_write(7'(a), pat(a, 8'h5A), a < 4);
    for (int a = 0; a < 128; a++) do_read(7'(a), pat(a, 8'h5A), a % 16 == 0);

    // R4: overwrite odd locations only; even ones keep their value
    for (int a = 1; a < 128; a += 2) do_write(7'(a), pat(a, 8'hC3), 1'b0);
    for (int a = 0; a < 128; a++)
      do_read(7'(a), (a % 2) ? pat(a, 8'hC3) : pat(a, 8'h5A), 1'b0);

    // R7: both strobes together, no drive, no ready, no write
    latch_addr(7'd10);
    bus_din = 8'hEE;
    bus_rd_n = 1'b0; bus_wr_n = 1'b0;
    rdy_seen = 0; doe_seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!bus_rdy_n) rdy_seen++;
      if (bus_doe) doe_seen++;
    end
    check("R7 conflict ready", rdy_seen, 0);
    check("R7 conflict doe", doe_seen, 0);
    bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    repeat (6) @(negedge clk);
    do_read(7'd10, pat(10, 8'h5A), 1'b1);

    // R8: synchronous reset mid-run clears contents
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_read(7'd3, 8'h00, 1'b0);
    do_read(7'd127, 8'h00, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule